// File: doc/BRIEF.md
# Debug Command Register and Session Flag

This block sits behind a boundary-scan TAP state machine and holds the command that steers a processor's debug port. A command byte is shifted in serially from TDI while the TAP is in shift-IR. It is copied to a holding register when the TAP passes through update-IR. The held command carries a read/write flag, a GO bit, an EX bit and a register-select code. Those fields drive the register-select outputs continuously. Any resource access, single-step launch or exit from debug is started only when the TAP passes through update-DR, even for commands that carry no data.

The block also keeps a sticky debug-session flag for peripherals. The flag rises when the CPU first reports that it is in the debug state. It stays high while the CPU steps in and out of debug for single instructions. It falls only when a release command (GO and EX both set, selecting either no register or the CPU scan-chain register) completes its update-DR. All logic runs on TCK. The TAP and the CPU are external; their state strobes and the CPU debug indication are inputs.

Top module: `dbg_cmd_ctrl`

## Requirements
- R1: While tap_shift_ir is high, each TCK edge shifts the 8-bit command shifter one place toward bit 0, with tdi entering at bit 7 (least significant bit first). tdo always equals bit 0 of the shifter.
- R2: A TCK edge with tap_capture_ir high loads the shifter with 8'b0000_0001, so tdo reads 1 in the following cycle.
- R3: The held command changes only on a TCK edge with tap_update_ir or tap_reset high. On update-IR it takes the shifter value. sel_reg shows held bits 4:0 and rd_wr shows held bit 7.
- R4: access_pulse is high exactly in cycles where tap_update_dr is high and the held register select is not 5'h1F.
- R5: go_pulse is high exactly in cycles where tap_update_dr is high and held bit 6 (GO) is set.
- R6: exit_pulse is high exactly in cycles where tap_update_dr is high, held bits 6 (GO) and 5 (EX) are both set, and the register select is 5'h1F (none) or 5'h00 (CPU scan chain).
- R7: debug_active rises on the TCK edge after cpu_in_debug is first seen high. It stays high across single-step commands (GO set, EX clear) and across the CPU leaving and re-entering debug.
- R8: debug_active clears on the TCK edge that ends a cycle with exit_pulse high, and this takes priority over cpu_in_debug in the same cycle. A GO+EX command that selects any other register does not clear it.
- R9: A TCK edge with tap_reset high sets the held command to select 5'h1F with R/W, GO and EX all zero, and leaves debug_active unchanged.
- R10: Driving rst_n low immediately clears the shifter, sets the held command to select 5'h1F with the other bits zero, and clears debug_active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial command input |
| tap_capture_ir | input | 1 | TAP in capture-IR |
| tap_shift_ir | input | 1 | TAP in shift-IR |
| tap_update_ir | input | 1 | TAP in update-IR |
| tap_update_dr | input | 1 | TAP in update-DR |
| tap_reset | input | 1 | TAP in test-logic-reset |
| cpu_in_debug | input | 1 | CPU reports debug state |
| tdo | output | 1 | Serial output from shifter bit 0 |
| sel_reg | output | 5 | Held register select |
| rd_wr | output | 1 | Held read/write flag |
| access_pulse | output | 1 | Start access to selected resource |
| go_pulse | output | 1 | Launch CPU (step or run) |
| exit_pulse | output | 1 | Release CPU from debug session |
| debug_active | output | 1 | Sticky debug-session flag |

## Verification
The bench builds the block with its default parameters: an 8-bit command, a 5-bit select, 5'h1F as the empty select, 5'h00 as the CPU scan-chain select, and a two-stage reset synchronizer. With these values every decode boundary can be reached through real serial scans. This covers both release selects, a GO+EX command that selects another register and therefore must not release, single-step with EX clear, an exit that coincides with the CPU debug indication, test-logic-reset while a session is active, and an update-DR with only the reset-default command held.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;
  localparam int unsigned CMD_W_DEF = 8;
  localparam int unsigned RS_W_DEF  = 5;

  typedef struct packed {
    logic rw;
    logic go;
    logic ex;
  } cmd_ctl_t;
endpackage

// File: rtl/dbg_ir_shift.sv
module dbg_ir_shift #(
  parameter int unsigned CMD_W   = 8,
  parameter int unsigned RS_W    = 5,
  parameter logic [CMD_W-1:0] CAP_VAL = 8'h01,
  parameter logic [RS_W-1:0]  RS_NONE = 5'h1F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tdi,
  input  logic             capture,
  input  logic             shift,
  input  logic             update,
  input  logic             tlr,
  output logic             tdo,
  output logic [CMD_W-1:0] held
);
  localparam logic [CMD_W-1:0] IDLE_CMD = {{(CMD_W-RS_W){1'b0}}, RS_NONE};

  logic [CMD_W-1:0] sh_q, sh_d, held_q, held_d;
  logic             sh_en, held_en;

  always_comb begin
    sh_en = capture | shift;
    if (capture) sh_d = CAP_VAL;
    else         sh_d = {tdi, sh_q[CMD_W-1:1]};
  end

  always_comb begin
    held_en = tlr | update;
    if (tlr) held_d = IDLE_CMD;
    else     held_d = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= IDLE_CMD;
    else if (held_en) held_q <= held_d;
  end

  assign tdo  = sh_q[0];
  assign held = held_q;
endmodule

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
  import dbg_cmd_pkg::*;
#(
  parameter int unsigned CMD_W = 8,
  parameter int unsigned RS_W  = 5,
  parameter logic [RS_W-1:0] RS_NONE = 5'h1F,
  parameter logic [RS_W-1:0] RS_CPU  = 5'h00
) (
  input  logic [CMD_W-1:0] held,
  input  logic             update_dr,
  output logic [RS_W-1:0]  sel,
  output cmd_ctl_t         ctl,
  output logic             access,
  output logic             go,
  output logic             leave
);
  logic no_sel, cpu_sel, release_sel;

  always_comb begin
    sel         = held[RS_W-1:0];
    ctl.rw      = held[CMD_W-1];
    ctl.go      = held[CMD_W-2];
    ctl.ex      = held[CMD_W-3];
    no_sel      = (sel == RS_NONE);
    cpu_sel     = (sel == RS_CPU);
    release_sel = no_sel | cpu_sel;
    access      = update_dr & ~no_sel;
    go          = update_dr & ctl.go;
    leave       = update_dr & ctl.go & ctl.ex & release_sel;
  end
endmodule

// File: rtl/dbg_session.sv
module dbg_session (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_dbg,
  input  logic leave,
  output logic active
);
  logic act_q, act_d, act_en;

  always_comb begin
    act_en = leave | cpu_dbg;
    act_d  = ~leave;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= 1'b0;
    else if (act_en) act_q <= act_d;
  end

  assign active = act_q;
endmodule

// File: rtl/dbg_cmd_ctrl.sv
module dbg_cmd_ctrl
  import dbg_cmd_pkg::*;
#(
  parameter int unsigned CMD_W       = CMD_W_DEF,
  parameter int unsigned RS_W        = RS_W_DEF,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [CMD_W-1:0] CAP_VAL = 8'h01,
  parameter logic [RS_W-1:0]  RS_NONE = 5'h1F,
  parameter logic [RS_W-1:0]  RS_CPU  = 5'h00
) (
  input  logic            tck,
  input  logic            rst_n,
  input  logic            tdi,
  input  logic            tap_capture_ir,
  input  logic            tap_shift_ir,
  input  logic            tap_update_ir,
  input  logic            tap_update_dr,
  input  logic            tap_reset,
  input  logic            cpu_in_debug,
  output logic            tdo,
  output logic [RS_W-1:0] sel_reg,
  output logic            rd_wr,
  output logic            access_pulse,
  output logic            go_pulse,
  output logic            exit_pulse,
  output logic            debug_active
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;
  logic [CMD_W-1:0]       held;
  cmd_ctl_t               ctl;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  dbg_ir_shift #(
    .CMD_W(CMD_W), .RS_W(RS_W), .CAP_VAL(CAP_VAL), .RS_NONE(RS_NONE)
  ) u_ir (
    .clk(tck), .rst_n(rst_int_n), .tdi(tdi),
    .capture(tap_capture_ir), .shift(tap_shift_ir),
    .update(tap_update_ir), .tlr(tap_reset),
    .tdo(tdo), .held(held)
  );

  dbg_cmd_decode #(
    .CMD_W(CMD_W), .RS_W(RS_W), .RS_NONE(RS_NONE), .RS_CPU(RS_CPU)
  ) u_dec (
    .held(held), .update_dr(tap_update_dr),
    .sel(sel_reg), .ctl(ctl),
    .access(access_pulse), .go(go_pulse), .leave(exit_pulse)
  );

  assign rd_wr = ctl.rw;

  dbg_session u_sess (
    .clk(tck), .rst_n(rst_int_n), .cpu_dbg(cpu_in_debug),
    .leave(exit_pulse), .active(debug_active)
  );
endmodule

// File: rtl/dbg_cmd_ctrl_chk.sv
module dbg_cmd_ctrl_chk #(
  parameter int unsigned RS_W = 5,
  parameter logic [RS_W-1:0] RS_NONE = 5'h1F
) (
  input logic            tck,
  input logic            rst_n,
  input logic            tap_update_ir,
  input logic            tap_update_dr,
  input logic            tap_reset,
  input logic            cpu_in_debug,
  input logic [RS_W-1:0] sel_reg,
  input logic            rd_wr,
  input logic            access_pulse,
  input logic            go_pulse,
  input logic            exit_pulse,
  input logic            debug_active
);
  a_r3_hold_stable: assert property (@(posedge tck) disable iff (!rst_n)
    (!tap_update_ir && !tap_reset) |=> ($stable(sel_reg) && $stable(rd_wr)));

  a_r4_access_needs_update: assert property (@(posedge tck) disable iff (!rst_n)
    access_pulse |-> tap_update_dr);

  a_r5_go_needs_update: assert property (@(posedge tck) disable iff (!rst_n)
    go_pulse |-> tap_update_dr);

  a_r6_exit_implies_go: assert property (@(posedge tck) disable iff (!rst_n)
    exit_pulse |-> go_pulse);

  a_r7_rise_after_cpu: assert property (@(posedge tck) disable iff (!rst_n)
    (cpu_in_debug && !exit_pulse) |=> debug_active);

  a_r8_exit_clears: assert property (@(posedge tck) disable iff (!rst_n)
    exit_pulse |=> !debug_active);

  a_r9_tlr_idle: assert property (@(posedge tck) disable iff (!rst_n)
    tap_reset |=> (sel_reg == RS_NONE && !rd_wr));

  a_r9_tlr_keeps_debug: assert property (@(posedge tck) disable iff (!rst_n)
    (tap_reset && !exit_pulse && !cpu_in_debug) |=> $stable(debug_active));
endmodule

bind dbg_cmd_ctrl dbg_cmd_ctrl_chk #(.RS_W(RS_W), .RS_NONE(RS_NONE)) u_chk (
  .tck(tck), .rst_n(rst_n), .tap_update_ir(tap_update_ir),
  .tap_update_dr(tap_update_dr), .tap_reset(tap_reset),
  .cpu_in_debug(cpu_in_debug), .sel_reg(sel_reg), .rd_wr(rd_wr),
  .access_pulse(access_pulse), .go_pulse(go_pulse),
  .exit_pulse(exit_pulse), .debug_active(debug_active)
);

// File: tb/dbg_cmd_ctrl_test.sv
module dbg_cmd_ctrl_test;
  logic tck = 1'b0;
  logic rst_n = 1'b0;
  logic tdi = 1'b0, cap_ir = 1'b0, sh_ir = 1'b0, up_ir = 1'b0;
  logic up_dr = 1'b0, tlr = 1'b0, cpu_dbg = 1'b0;
  logic tdo, rd_wr, access_pulse, go_pulse, exit_pulse, debug_active;
  logic [4:0] sel_reg;

  int total = 0;
  int bad = 0;
  bit compare_on = 1'b0;

  // reference state
  logic [7:0] m_sh, m_held;
  logic       m_dbg;

  always #5 tck = ~tck;

  dbg_cmd_ctrl uut (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .tap_capture_ir(cap_ir),
    .tap_shift_ir(sh_ir), .tap_update_ir(up_ir), .tap_update_dr(up_dr),
    .tap_reset(tlr), .cpu_in_debug(cpu_dbg), .tdo(tdo), .sel_reg(sel_reg),
    .rd_wr(rd_wr), .access_pulse(access_pulse), .go_pulse(go_pulse),
    .exit_pulse(exit_pulse), .debug_active(debug_active)
  );

  function automatic logic f_exit(input logic [7:0] h, input logic u);
    return u && h[6] && h[5] && (h[4:0] == 5'h1F || h[4:0] == 5'h00);
  endfunction

  always @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      m_sh = 8'h00; m_held = 8'h1F; m_dbg = 1'b0;
    end else begin
      if (f_exit(m_held, up_dr)) m_dbg = 1'b0;
      else if (cpu_dbg)          m_dbg = 1'b1;
      if (tlr)        m_held = 8'h1F;
      else if (up_ir) m_held = m_sh;
      if (cap_ir)     m_sh = 8'h01;
      else if (sh_ir) m_sh = {tdi, m_sh[7:1]};
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge tck) if (compare_on) begin
    chk("R1 tdo", tdo, m_sh[0]);
    chk("R3 sel_reg", sel_reg, m_held[4:0]);
    chk("R3 rd_wr", rd_wr, m_held[7]);
    chk("R4 access", access_pulse, up_dr && m_held[4:0] != 5'h1F);
    chk("R5 go", go_pulse, up_dr && m_held[6]);
    chk("R6 exit", exit_pulse, f_exit(m_held, up_dr));
    chk("R7/R8 debug", debug_active, m_dbg);
  end

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge tck); #2;
    end
  endtask

  task automatic load_ir(input logic [7:0] cmd);
    cap_ir = 1'b1; cyc();
    cap_ir = 1'b0; sh_ir = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tdi = cmd[i]; cyc();
    end
    sh_ir = 1'b0; tdi = 1'b0; up_ir = 1'b1; cyc();
    up_ir = 1'b0; cyc();
  endtask

  task automatic upd_dr();
    up_dr = 1'b1; cyc();
    up_dr = 1'b0; cyc();
  endtask

  initial begin
    cyc(2);
    chk("R10 reset sel", sel_reg, 5'h1F);
    chk("R10 reset debug", debug_active, 0);
    rst_n = 1'b1;
    cyc(4);
    compare_on = 1'b1;
    // R4 R5 R6: update-DR with only default command held
    upd_dr();
    // R2: capture value visible on tdo
    cap_ir = 1'b1; cyc(); cap_ir = 1'b0;
    @(negedge tck); chk("R2 capture tdo", tdo, 1); cyc();
    // R7: session start, single step keeps it
    cpu_dbg = 1'b1; cyc(); cpu_dbg = 1'b0; cyc();
    @(negedge tck); chk("R7 debug set", debug_active, 1); cyc();
    load_ir(8'h43); upd_dr();
    cpu_dbg = 1'b1; cyc(); cpu_dbg = 1'b0; cyc(2);
    load_ir(8'h40); upd_dr();
    @(negedge tck); chk("R7 step keeps debug", debug_active, 1); cyc();
    // R8: GO+EX with other select does not release
    load_ir(8'h65); upd_dr();
    @(negedge tck); chk("R8 other sel keeps", debug_active, 1); cyc();
    // R6 R8: release with CPU scan-chain select
    load_ir(8'h60); upd_dr();
    @(negedge tck); chk("R8 release cpu sel", debug_active, 0); cyc();
    // R8: exit wins over simultaneous cpu_in_debug
    cpu_dbg = 1'b1; cyc(); cpu_dbg = 1'b0;
    load_ir(8'hFF);
    cpu_dbg = 1'b1; up_dr = 1'b1; cyc(); up_dr = 1'b0; cpu_dbg = 1'b0;
    @(negedge tck); chk("R8 exit priority", debug_active, 0); cyc();
    // R9: test-logic-reset keeps session
    cpu_dbg = 1'b1; cyc(); cpu_dbg = 1'b0;
    load_ir(8'hA7);
    tlr = 1'b1; cyc(); tlr = 1'b0;
    @(negedge tck);
    chk("R9 tlr sel", sel_reg, 5'h1F);
    chk("R9 tlr debug kept", debug_active, 1);
    cyc();
    upd_dr();
    // R1: other patterns
    load_ir(8'h9C); upd_dr();
    load_ir(8'h3E); upd_dr();
    // R10: asynchronous reset mid-run
    compare_on = 1'b0;
    #1 rst_n = 1'b0; #1;
    chk("R10 async sel", sel_reg, 5'h1F);
    chk("R10 async debug", debug_active, 0);
    chk("R10 async tdo", tdo, 0);
    cyc(2); rst_n = 1'b1; cyc(4);
    compare_on = 1'b1;
    load_ir(8'h60); upd_dr();
    compare_on = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule